// File: doc/BRIEF.md
# Pulse Re-arm Protocol Monitor

This block is a synthesizable run-time checker for a simple spacing rule between two single-bit signals sharing one clock. A "trigger" is a pulse on `a_in` that stays high for exactly one sampled cycle. Once such a pulse has completed, a lockout window opens. Another trigger is forbidden while the window is open. The window closes when `b_in` is sampled high, or after a fixed number of cycles, whichever comes first.

Wider pulses on `a_in`, two cycles or longer, are not triggers and are ignored entirely. A trigger inside an open window is a violation. The block raises a one-cycle violation flag and sets a sticky error bit. It then restarts the window as though the offending trigger were a fresh one. The current state of the window is visible on a status output, so the block can be dropped next to any two handshake-like signals and watched from a chip-level monitor.

Top module: `pulse_rearm_monitor`

## Requirements
- R1: While `rst` is high at a rising clock edge, `win_o`, `viol_o` and `err_o` are all cleared, and all internal pulse history is cleared.
- R2: A trigger completes at the edge where `a_in` is sampled low after being sampled high for exactly one edge, with low at the edge before that (or reset). After that edge `win_o` is 1.
- R3: A pulse on `a_in` sampled high at two or more consecutive edges is ignored. It neither opens nor restarts the window, and it never raises `viol_o`.
- R4: With the window open, the first edge at which `b_in` is sampled high closes it, so `win_o` is 0 after that edge.
- R5: Without `b_in`, the window stays open for exactly `LOCK_CYCLES` cycles (default 10) after the trigger edge. It closes at the `LOCK_CYCLES`-th edge after the trigger.
- R6: A trigger completing while the window is open, with no release at that same edge, makes `viol_o` 1 for exactly the one cycle after that edge.
- R7: `err_o` becomes 1 together with the first `viol_o` pulse and stays 1 until reset.
- R8: A violating trigger restarts the window, which then stays open `LOCK_CYCLES` cycles from the violating edge.
- R9: If a release (`b_in` high, or the timeout edge) coincides with a trigger edge, the release is applied first. The trigger is legal and reopens the window with no violation.
- R10: When `b_in` is high at the same edge as the timeout, the window closes exactly once. No further event results and `err_o` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 1 | Monitored trigger signal |
| b_in | input | 1 | Monitored release signal |
| viol_o | output | 1 | One-cycle violation flag |
| err_o | output | 1 | Sticky error bit |
| win_o | output | 1 | Lockout window currently open |

## Verification
Every result of this block is due one register after its cause. A trigger, release or violation decided at clock edge n shows up on `win_o`, `viol_o` and `err_o` right after edge n. A trigger itself is decided at the edge where `a_in` is first sampled low again, one edge after its single high sample. The bench therefore applies each input pair just after a falling edge and advances its reference state at the following rising edge. It compares all three outputs at the next falling edge, before the next inputs go in. The sweep places a second trigger at every distance from the first, with and without a `b_in` sighting at every possible position, so each edge of the window boundary is sampled.

// File: rtl/prm_pkg.sv
package prm_pkg;

    // Default lockout length in clock cycles after a trigger.
    localparam int unsigned LOCK_CYCLES_DEF = 10;

    // History used to tell a one-cycle pulse from a wider one.
    typedef struct packed {
        logic a_q;    // a_in sampled at the previous edge
        logic pend;   // rising edge seen at the previous edge
    } qual_state_t;

    // Why the window closes at the current edge (B has priority).
    typedef enum logic [1:0] {
        REL_NONE    = 2'd0,
        REL_BSEEN   = 2'd1,
        REL_TIMEOUT = 2'd2
    } rel_cause_t;

    // Output flag register pair.
    typedef struct packed {
        logic viol;
        logic err;
    } flag_state_t;

    // Counter width for a lockout of n cycles (counts 0..n-1).
    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/prm_pulse_qual.sv
module prm_pulse_qual (
    input  logic clk,
    input  logic rst,
    input  logic a_in,
    output logic evt_o
);
    prm_pkg::qual_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q.a_q  <= a_in;
            st_q.pend <= a_in & ~st_q.a_q;
        end
    end

    // Trigger completes when the single high sample is followed by low.
    assign evt_o = st_q.pend & ~a_in;

    // R2: a trigger is always a high sample followed by a low one
    assert_evt_shape_R2: assert property (@(posedge clk) disable iff (rst)
        evt_o |-> (!a_in && $past(a_in)));

    // R3: two consecutive high samples never produce a trigger next edge
    assert_long_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (a_in && st_q.a_q) |=> !evt_o);

endmodule

// File: rtl/prm_lock_timer.sv
module prm_lock_timer #(
    parameter int unsigned LOCK_CYCLES = prm_pkg::LOCK_CYCLES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic evt_i,
    input  logic b_in,
    output logic win_o,
    output logic viol_c_o
);
    localparam int unsigned CW = prm_pkg::cnt_bits(LOCK_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(LOCK_CYCLES - 1);

    logic               open_q;
    logic [CW-1:0]      cnt_q;
    logic               timeout;
    logic               release_c;
    prm_pkg::rel_cause_t cause;

    always_comb begin
        timeout = open_q && (cnt_q == LAST);
        if (open_q && b_in)
            cause = prm_pkg::REL_BSEEN;
        else if (timeout)
            cause = prm_pkg::REL_TIMEOUT;
        else
            cause = prm_pkg::REL_NONE;
        release_c = (cause != prm_pkg::REL_NONE);
        // Release is applied before judging a coinciding trigger.
        viol_c_o  = evt_i && open_q && !release_c;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            cnt_q  <= '0;
        end else if (evt_i) begin
            open_q <= 1'b1;
            cnt_q  <= '0;
        end else if (release_c) begin
            open_q <= 1'b0;
            cnt_q  <= '0;
        end else if (open_q) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign win_o = open_q;

    // R4: B sighting closes an open window
    assert_brelease_R4: assert property (@(posedge clk) disable iff (rst)
        (open_q && b_in && !evt_i) |=> !open_q);

    // R5: counter never passes the last lockout cycle
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
        open_q |-> (cnt_q <= LAST));

    // R5: last lockout cycle without a trigger closes the window
    assert_timeout_R5: assert property (@(posedge clk) disable iff (rst)
        (open_q && cnt_q == LAST && !evt_i) |=> !open_q);

    // R8: every trigger leaves the window open with a fresh count
    assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
        evt_i |=> (open_q && cnt_q == '0));

    // R10: B together with timeout closes once and leaves the count cleared
    assert_single_close_R10: assert property (@(posedge clk) disable iff (rst)
        (open_q && b_in && cnt_q == LAST && !evt_i) |=> (!open_q && cnt_q == '0));

endmodule

// File: rtl/prm_flag_reg.sv
module prm_flag_reg (
    input  logic clk,
    input  logic rst,
    input  logic viol_c,
    output logic viol_o,
    output logic err_o
);
    prm_pkg::flag_state_t fl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fl_q <= '0;
        end else begin
            fl_q.viol <= viol_c;
            fl_q.err  <= fl_q.err | viol_c;
        end
    end

    assign viol_o = fl_q.viol;
    assign err_o  = fl_q.err;

    // R6: violation flag is a single-cycle pulse
    assert_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        viol_o |=> !viol_o);

    // R7: error bit never falls outside reset
    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);

    // R7: a violation pulse always comes with the error bit
    assert_err_with_viol_R7: assert property (@(posedge clk) disable iff (rst)
        viol_o |-> err_o);

endmodule

// File: rtl/pulse_rearm_monitor.sv
module pulse_rearm_monitor #(
    parameter int unsigned LOCK_CYCLES = prm_pkg::LOCK_CYCLES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic a_in,
    input  logic b_in,
    output logic viol_o,
    output logic err_o,
    output logic win_o
);
    logic evt;
    logic viol_c;

    prm_pulse_qual u_qual (
        .clk   (clk),
        .rst   (rst),
        .a_in  (a_in),
        .evt_o (evt)
    );

    prm_lock_timer #(
        .LOCK_CYCLES (LOCK_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .evt_i    (evt),
        .b_in     (b_in),
        .win_o    (win_o),
        .viol_c_o (viol_c)
    );

    prm_flag_reg u_flags (
        .clk    (clk),
        .rst    (rst),
        .viol_c (viol_c),
        .viol_o (viol_o),
        .err_o  (err_o)
    );

    // R6: a violation is only reported while a window was open
    assert_viol_needs_win_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(viol_o) |-> $past(win_o));

endmodule

// File: tb/tb_pulse_rearm_monitor.sv
`timescale 1ns/1ps
module tb_pulse_rearm_monitor;
    localparam int LOCK = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a = 1'b0;
    logic b = 1'b0;
    logic viol_o, err_o, win_o;

    always #4 clk = ~clk;

    pulse_rearm_monitor #(.LOCK_CYCLES(LOCK)) dut (
        .clk(clk), .rst(rst), .a_in(a), .b_in(b),
        .viol_o(viol_o), .err_o(err_o), .win_o(win_o)
    );

    int checks = 0;
    int fails  = 0;

    // Reference state: edge index, edge of last trigger, window bookkeeping.
    int n = 0;
    int e_edge = 0;
    bit m_has = 0, m_closed = 0, m_preva = 0, m_pend = 0;
    bit x_viol = 0, x_err = 0;

    task automatic chk(input string tag, input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s at edge %0d got=%0b exp=%0b", tag, what, n, got, exp);
        end
    endtask

    task automatic model_edge(input bit ai, input bit bi);
        bit evt, open_pre, rel, vi;
        n++;
        evt      = m_pend && !ai;
        open_pre = m_has && !m_closed && ((n - e_edge) <= LOCK);
        rel      = open_pre && (bi || ((n - e_edge) == LOCK));
        vi       = evt && open_pre && !rel;
        m_pend   = ai && !m_preva;
        m_preva  = ai;
        if (evt) begin
            e_edge = n; m_has = 1; m_closed = 0;
        end else if (rel) begin
            m_closed = 1;
        end
        x_viol = vi;
        x_err  = x_err | vi;
    endtask

    function automatic bit exp_win();
        return m_has && !m_closed && ((n - e_edge) < LOCK);
    endfunction

    task automatic step(input string tag, input bit ai, input bit bi);
        a = ai; b = bi;
        @(posedge clk);
        model_edge(ai, bi);
        @(negedge clk);
        chk(tag, "win_o", win_o, exp_win());
        chk(tag, "viol_o", viol_o, x_viol);
        chk(tag, "err_o", err_o, x_err);
    endtask

    task automatic do_reset();
        a = 0; b = 0; rst = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        n = 0; e_edge = 0; m_has = 0; m_closed = 0; m_preva = 0; m_pend = 0;
        x_viol = 0; x_err = 0;
        chk("R1", "win_o after reset", win_o, 1'b0);
        chk("R1", "viol_o after reset", viol_o, 1'b0);
        chk("R1", "err_o after reset", err_o, 1'b0);
    endtask

    initial begin : main
        string tag;
        logic [15:0] lfsr;
        do_reset();

        // Second trigger at every distance d, B at every position bp (0 = none).
        for (int d = 2; d <= LOCK + 3; d++) begin
            for (int bp = 0; bp <= d; bp++) begin
                if (bp == d)                          tag = "R9 B with trigger";
                else if (bp == LOCK && d > LOCK)      tag = "R10 B with timeout";
                else if (bp > 0 && bp < d && bp <= LOCK) tag = "R4 B release";
                else if (d == LOCK)                   tag = "R9 timeout with trigger";
                else if (d > LOCK)                    tag = "R5 timeout";
                else                                  tag = "R6 repeat in window";
                do_reset();
                step("R2 first pulse", 1, 0);
                step("R2 first trigger", 0, 0);
                for (int k = 1; k <= d; k++)
                    step(tag, (k == d - 1), (k == bp));
                for (int k = 1; k <= LOCK + 1; k++)
                    step(x_err ? "R8 restarted window" : "R5 window tail", 0, 0);
                chk("R7", "err_o held", err_o, x_err);
            end
        end

        // Wide pulses, with and without an open window.
        for (int len = 2; len <= 4; len++) begin
            for (int pre = 0; pre <= 1; pre++) begin
                do_reset();
                if (pre == 1) begin
                    step("R2 pulse", 1, 0);
                    step("R2 trigger", 0, 0);
                end
                for (int k = 0; k < len; k++) step("R3 wide pulse", 1, 0);
                for (int k = 0; k < LOCK + 2; k++) step("R3 after wide pulse", 0, 0);
            end
        end

        // Pseudo-random mix of both inputs.
        do_reset();
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step("R6 random mix", (lfsr[1:0] == 2'b01), (lfsr[5:3] == 3'b111));
        end
        chk("R7", "err_o end of mix", err_o, x_err);

        // Reset clears a set error bit.
        do_reset();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog got=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule